// File: doc/BRIEF.md
# Clock Control Register Bank with Frequency Derivation

This block holds twenty-eight 32-bit control words behind a simple word-wide read/write bus and works out the processor and bus clock rates from one of them. At reset each word takes a fixed preset value. The bus accepts only full-word, word-aligned accesses inside the decoded window. It flags any other access and leaves the stored state unchanged.

A separate query port takes a 4-bit clock selector and returns a 32-bit frequency in hertz. The processor rate starts from the main PLL rate. That rate is either the 24 MHz crystal, when bypass is set, or a value supplied by an external PLL model on `pll_hz`. It is optionally scaled by 3/4 and then divided by a small field. The AHB rate divides the processor rate again, and the IPG rate is half the AHB rate. Every division truncates.

Two small state machines run the block. The bus machine has states `BUS_IDLE` and `BUS_DONE`. A request in any state moves it to `BUS_DONE`, which drives the acknowledge. With no request it returns to `BUS_IDLE`. The query machine has states `Q_IDLE` and `Q_RESP`. It leaves `Q_IDLE` for `Q_RESP` when a query is accepted, and always returns to `Q_IDLE` on the next cycle.

Top module: `clkctl_bank`

## Requirements
- R1: After reset every word reads zero except these words, where word n lives at byte offset 4n: word 0 = 0x800B2C01, word 1 = 0x84042800, word 2 = 0xD0030000, word 3 = 0x028A0100, word 4 = 0x04008100, word 5 = 0x00000438, words 6 to 9 = 0x01010101, word 22 = 0x00A00000, words 23 and 24 = 0x0000A030, word 25 = 0x43000000.
- R2: A legal access (offset below 0x70, `bus_addr[1:0]`=0, `bus_be`=4'hF) is acknowledged one cycle after `bus_req`. A legal write stores all 32 bits, and a legal read returns the stored word with `bus_err` low.
- R3: An access at offset 0x70 or above is acknowledged with `bus_err` high. A read returns zero, and a write changes no stored word.
- R4: A misaligned access or one whose `bus_be` is not 4'hF is acknowledged with `bus_err` high and read data zero, and it changes no stored word.
- R5: When bit 22 of word 2 (bypass) is set, the main PLL rate is 24,000,000. Otherwise it is `pll_hz`.
- R6: The processor rate is the main PLL rate, first multiplied by 3 and divided by 4 when bit 14 of word 2 is set, then divided by (1 + word 2 bits 31:30). There is no overflow for any 32-bit `pll_hz`.
- R7: The AHB rate is the processor rate divided by (1 + word 2 bits 29:28).
- R8: Selectors 1 and 2 both return half the AHB rate.
- R9: Selector 3 returns 32768 and selector 0 returns zero, both with `resp_err` low. Selectors 4 to 15 return zero with `resp_err` high.
- R10: `q_ready` is high in `Q_IDLE`. `resp_valid` rises exactly one cycle after a query is accepted, and `q_ready` is low while `resp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_be | input | 4 | Byte enables, must be all ones |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access completed |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_err | output | 1 | Illegal access, valid with bus_ack |
| pll_hz | input | 32 | Main PLL rate from the PLL model |
| q_valid | input | 1 | Frequency query request |
| q_sel | input | 4 | Clock selector |
| q_ready | output | 1 | Query can be accepted |
| resp_valid | output | 1 | Query result valid |
| resp_freq | output | 32 | Frequency in hertz |
| resp_err | output | 1 | Unsupported selector |

## Verification
Bus acknowledge, read data and error all appear one cycle after the request edge. The query result appears one cycle after the accepting edge. The bench drives every input on a falling edge, waits one rising edge, and samples on the next falling edge, so each result is read in the cycle it is due. The frequency sweep covers every combination of the two divider fields, the 3/4 source bit and bypass for three PLL rates, including the all-ones rate, and it queries every selector value.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    parameter int DATA_W   = 32;
    parameter int NUM_REGS = 28;
    parameter int ADDR_W   = 12;
    parameter int SEL_W    = 4;

    localparam int IDX_W   = $clog2(NUM_REGS);
    localparam int CTL_IDX = 2;

    // bit positions inside the clock control word
    localparam int CPU_DIV_LSB = 30;
    localparam int AHB_DIV_LSB = 28;
    localparam int BYPASS_BIT  = 22;
    localparam int SRC_BIT     = 14;
    localparam int DIV_W       = 2;

    localparam logic [DATA_W-1:0] XTAL_HZ = 32'd24_000_000;
    localparam logic [DATA_W-1:0] SLOW_HZ = 32'd32_768;

    localparam logic [SEL_W-1:0] SEL_NONE   = 4'd0;
    localparam logic [SEL_W-1:0] SEL_IPG    = 4'd1;
    localparam logic [SEL_W-1:0] SEL_IPG_HI = 4'd2;
    localparam logic [SEL_W-1:0] SEL_SLOW   = 4'd3;

    typedef enum logic [0:0] {BUS_IDLE, BUS_DONE} bus_state_t;
    typedef enum logic [0:0] {Q_IDLE, Q_RESP} q_state_t;

    function automatic logic [DATA_W-1:0] preset(input int idx);
        case (idx)
            0:              preset = 32'h800B_2C01;
            1:              preset = 32'h8404_2800;
            2:              preset = 32'hD003_0000;
            3:              preset = 32'h028A_0100;
            4:              preset = 32'h0400_8100;
            5:              preset = 32'h0000_0438;
            6, 7, 8, 9:     preset = 32'h0101_0101;
            22:             preset = 32'h00A0_0000;
            23, 24:         preset = 32'h0000_A030;
            25:             preset = 32'h4300_0000;
            default:        preset = '0;
        endcase
    endfunction

endpackage

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
    import clkctl_pkg::*;
#(
    parameter int N_REGS = NUM_REGS,
    parameter int AW     = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic [DIV_W-1:0]  cpu_div,
    output logic [DIV_W-1:0]  ahb_div,
    output logic              bypass,
    output logic              cpu_src
);

    localparam int LIMIT = N_REGS * 4;
    localparam int IW    = $clog2(N_REGS);

    bus_state_t        state, nxt;
    logic [DATA_W-1:0] regs [N_REGS];
    logic              legal;
    logic [IW-1:0]     idx;
    logic [DATA_W-1:0] rd_word;

    assign legal = (bus_addr < AW'(LIMIT)) && (bus_addr[1:0] == 2'b00) && (bus_be == 4'hF);
    assign idx   = bus_addr[IW+1:2];

    generate
        for (genvar g = 0; g < N_REGS; g++) begin : g_word
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= preset(g);
                else if (bus_req && bus_we && legal && (idx == IW'(g)))
                    q <= bus_wdata;
            end
            assign regs[g] = q;
        end
    endgenerate

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < N_REGS; i++)
            if (idx == IW'(i)) rd_word = regs[i];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            BUS_IDLE: nxt = bus_req ? BUS_DONE : BUS_IDLE;
            BUS_DONE: nxt = bus_req ? BUS_DONE : BUS_IDLE;
            default:  nxt = BUS_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else if (bus_req) begin
            bus_err   <= !legal;
            bus_rdata <= (legal && !bus_we) ? rd_word : '0;
        end
    end

    assign bus_ack = (state == BUS_DONE);

    assign cpu_div = regs[CTL_IDX][CPU_DIV_LSB +: DIV_W];
    assign ahb_div = regs[CTL_IDX][AHB_DIV_LSB +: DIV_W];
    assign bypass  = regs[CTL_IDX][BYPASS_BIT];
    assign cpu_src = regs[CTL_IDX][SRC_BIT];

endmodule

// File: rtl/clkctl_freq_calc.sv
module clkctl_freq_calc
    import clkctl_pkg::*;
(
    input  logic [DATA_W-1:0] pll_hz,
    input  logic [DIV_W-1:0]  cpu_div,
    input  logic [DIV_W-1:0]  ahb_div,
    input  logic              bypass,
    input  logic              cpu_src,
    output logic [DATA_W-1:0] ipg_hz
);

    logic [DATA_W-1:0] mpll_hz, src_hz, cpu_hz, ahb_hz;
    logic [DATA_W+1:0] triple;

    function automatic logic [DATA_W-1:0] div_small(input logic [DATA_W-1:0] x,
                                                    input logic [DIV_W-1:0] d);
        case (d)
            2'd0:    div_small = x;
            2'd1:    div_small = x >> 1;
            2'd2:    div_small = x / 3;
            default: div_small = x >> 2;
        endcase
    endfunction

    always_comb begin
        mpll_hz = bypass ? XTAL_HZ : pll_hz;
        triple  = {2'b00, mpll_hz} * 34'd3;
        src_hz  = cpu_src ? triple[DATA_W+1:2] : mpll_hz;
        cpu_hz  = div_small(src_hz, cpu_div);
        ahb_hz  = div_small(cpu_hz, ahb_div);
        ipg_hz  = ahb_hz >> 1;
    end

endmodule

// File: rtl/clkctl_query_fsm.sv
module clkctl_query_fsm
    import clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_valid,
    input  logic [SEL_W-1:0]  q_sel,
    input  logic [DATA_W-1:0] ipg_hz,
    output logic              q_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_freq,
    output logic              resp_err
);

    q_state_t          state, nxt;
    logic              take;
    logic [DATA_W-1:0] pick;
    logic              bad;

    assign take = q_valid && (state == Q_IDLE);

    always_comb begin
        bad = 1'b0;
        unique case (q_sel)
            SEL_NONE:            pick = '0;
            SEL_IPG, SEL_IPG_HI: pick = ipg_hz;
            SEL_SLOW:            pick = SLOW_HZ;
            default: begin
                pick = '0;
                bad  = 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            Q_IDLE:  nxt = take ? Q_RESP : Q_IDLE;
            Q_RESP:  nxt = Q_IDLE;
            default: nxt = Q_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_freq <= '0;
            resp_err  <= 1'b0;
        end else if (take) begin
            resp_freq <= pick;
            resp_err  <= bad;
        end
    end

    assign q_ready    = (state == Q_IDLE);
    assign resp_valid = (state == Q_RESP);

endmodule

// File: rtl/clkctl_bank.sv
module clkctl_bank
    import clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic [DATA_W-1:0] pll_hz,
    input  logic              q_valid,
    input  logic [SEL_W-1:0]  q_sel,
    output logic              q_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_freq,
    output logic              resp_err
);

    logic [DIV_W-1:0]  cpu_div, ahb_div;
    logic              bypass, cpu_src;
    logic [DATA_W-1:0] ipg_hz;

    clkctl_regfile #(.N_REGS(NUM_REGS), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .cpu_div(cpu_div), .ahb_div(ahb_div), .bypass(bypass), .cpu_src(cpu_src)
    );

    clkctl_freq_calc u_calc (
        .pll_hz(pll_hz), .cpu_div(cpu_div), .ahb_div(ahb_div),
        .bypass(bypass), .cpu_src(cpu_src), .ipg_hz(ipg_hz)
    );

    clkctl_query_fsm u_query (
        .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_sel(q_sel),
        .ipg_hz(ipg_hz), .q_ready(q_ready), .resp_valid(resp_valid),
        .resp_freq(resp_freq), .resp_err(resp_err)
    );

endmodule

// File: rtl/clkctl_bank_chk.sv
module clkctl_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic        bus_ack,
    input logic        bus_err,
    input logic [31:0] bus_rdata,
    input logic        q_valid,
    input logic [3:0]  q_sel,
    input logic        q_ready,
    input logic        resp_valid,
    input logic [31:0] resp_freq,
    input logic        resp_err
);

    p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_ack);

    p_no_spurious_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_ack);

    p_err_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && bus_err) |-> (bus_rdata == 32'd0));

    p_resp_after_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && q_ready) |=> resp_valid);

    p_busy_during_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !q_ready);

    p_bad_sel_flagged_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && q_ready && (q_sel > 4'd3)) |=> (resp_err && resp_freq == 32'd0));

    p_good_sel_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && q_ready && (q_sel <= 4'd3)) |=> !resp_err);

endmodule

bind clkctl_bank clkctl_bank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
    .bus_err(bus_err), .bus_rdata(bus_rdata), .q_valid(q_valid),
    .q_sel(q_sel), .q_ready(q_ready), .resp_valid(resp_valid),
    .resp_freq(resp_freq), .resp_err(resp_err)
);

// File: tb/tb_clkctl_bank.sv
module tb_clkctl_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack, bus_err;
    logic [31:0] bus_rdata;
    logic [31:0] pll_hz = 32'd532_000_000;
    logic        q_valid = 1'b0;
    logic [3:0]  q_sel = '0;
    logic        q_ready, resp_valid, resp_err;
    logic [31:0] resp_freq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    clkctl_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .pll_hz(pll_hz), .q_valid(q_valid), .q_sel(q_sel), .q_ready(q_ready),
        .resp_valid(resp_valid), .resp_freq(resp_freq), .resp_err(resp_err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] preset_of(input int i);
        case (i)
            0: return 32'h800B2C01;
            1: return 32'h84042800;
            2: return 32'hD0030000;
            3: return 32'h028A0100;
            4: return 32'h04008100;
            5: return 32'h00000438;
            6, 7, 8, 9: return 32'h01010101;
            22: return 32'h00A00000;
            23, 24: return 32'h0000A030;
            25: return 32'h43000000;
            default: return 32'h0;
        endcase
    endfunction

    // one access; results sampled on the falling edge after the capturing edge
    task automatic access(input bit we, input logic [11:0] a, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic err, output logic ack);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        rd = bus_rdata; err = bus_err; ack = bus_ack;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic query(input logic [3:0] s, output logic [31:0] f,
                         output logic e, output logic v, output logic rdy);
        @(negedge clk);
        rdy = q_ready;
        q_valid = 1'b1; q_sel = s;
        @(posedge clk);
        @(negedge clk);
        f = resp_freq; e = resp_err; v = resp_valid && !q_ready;
        q_valid = 1'b0;
    endtask

    function automatic longint exp_ipg(input longint pll, input int cd, input int ad,
                                       input bit byp, input bit src);
        longint m, c;
        m = byp ? 64'd24000000 : pll;
        if (src) m = (m * 3) / 4;
        c = m / (1 + cd);
        c = c / (1 + ad);
        return c / 2;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        finish_run();
    end

    initial begin
        logic [31:0] rd, f;
        logic err, ack, e, v, rdy;
        longint pls [3];
        pls[0] = 532000000; pls[1] = 399000000; pls[2] = 64'hFFFFFFFF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: preset values
        for (int i = 0; i < 28; i++) begin
            access(1'b0, 12'(i * 4), 4'hF, 32'h0, rd, err, ack);
            check(rd === preset_of(i) && !err && ack, "R1", rd, preset_of(i));
        end

        // R9/R8 at preset control word
        query(4'd1, f, e, v, rdy);
        check(f == 32'd33_250_000 && rdy && v, "R8", f, 33250000);

        // R2: write/read every word with a distinct pattern
        for (int i = 0; i < 28; i++) begin
            logic [31:0] pat;
            pat = 32'hA5000000 ^ (32'(i) * 32'h01010101) ^ 32'h00C3_3C00;
            access(1'b1, 12'(i * 4), 4'hF, pat, rd, err, ack);
            check(ack && !err && rd == 32'h0, "R2", {31'h0, err}, 0);
            access(1'b0, 12'(i * 4), 4'hF, 32'h0, rd, err, ack);
            check(rd == pat && !err && ack, "R2", rd, pat);
        end

        // R3: out-of-window accesses
        for (int a = 'h70; a < 'h80; a += 4) begin
            access(1'b1, 12'(a), 4'hF, 32'hDEADBEEF, rd, err, ack);
            check(err && ack, "R3", {31'h0, err}, 1);
            access(1'b0, 12'(a), 4'hF, 32'h0, rd, err, ack);
            check(err && rd == 32'h0, "R3", rd, 0);
        end
        access(1'b0, 12'hFFC, 4'hF, 32'h0, rd, err, ack);
        check(err && rd == 32'h0, "R3", rd, 0);
        access(1'b0, 12'h000, 4'hF, 32'h0, rd, err, ack);
        check(rd == (32'hA5000000 ^ 32'h00C33C00) && !err, "R3", rd, 32'hA5000000 ^ 32'h00C33C00);

        // R4: misaligned and partial byte enables
        access(1'b1, 12'h011, 4'hF, 32'h11111111, rd, err, ack);
        check(err && ack, "R4", {31'h0, err}, 1);
        access(1'b1, 12'h010, 4'h3, 32'h22222222, rd, err, ack);
        check(err && ack, "R4", {31'h0, err}, 1);
        access(1'b0, 12'h012, 4'hF, 32'h0, rd, err, ack);
        check(err && rd == 32'h0, "R4", rd, 0);
        access(1'b0, 12'h010, 4'h0, 32'h0, rd, err, ack);
        check(err && rd == 32'h0, "R4", rd, 0);
        access(1'b0, 12'h010, 4'hF, 32'h0, rd, err, ack);
        begin
            logic [31:0] p4;
            p4 = 32'hA5000000 ^ (32'd4 * 32'h01010101) ^ 32'h00C33C00;
            check(rd == p4 && !err, "R4", rd, p4);
        end

        // R5, R6, R7, R8: sweep divider fields, source, bypass, PLL rate
        for (int p = 0; p < 3; p++) begin
            pll_hz = pls[p][31:0];
            for (int cd = 0; cd < 4; cd++)
                for (int ad = 0; ad < 4; ad++)
                    for (int b = 0; b < 2; b++)
                        for (int s = 0; s < 2; s++) begin
                            logic [31:0] w;
                            longint ex;
                            w = {2'(cd), 2'(ad), 5'h0, 1'(b), 7'h0, 1'(s), 14'h0};
                            access(1'b1, 12'h008, 4'hF, w, rd, err, ack);
                            ex = exp_ipg(pls[p], cd, ad, b[0], s[0]);
                            query(4'd1, f, e, v, rdy);
                            check(f == ex[31:0] && !e && v && rdy, "R6_R7_R5", f, ex);
                            query(4'd2, f, e, v, rdy);
                            check(f == ex[31:0] && !e && v, "R8", f, ex);
                        end
        end

        // R9 and R10: every selector
        pll_hz = 32'd400_000_000;
        access(1'b1, 12'h008, 4'hF, 32'h5000_0000, rd, err, ack);
        for (int sl = 0; sl < 16; sl++) begin
            longint ex;
            bit eb;
            ex = (sl == 0) ? 0 : (sl <= 2) ? exp_ipg(400000000, 1, 1, 0, 0) :
                 (sl == 3) ? 32768 : 0;
            eb = (sl > 3);
            query(4'(sl), f, e, v, rdy);
            check(f == ex[31:0] && e == eb, "R9", f, ex);
            check(v && rdy, "R10", {30'h0, v, rdy}, 3);
        end

        // R10: ready returns one cycle after the response
        @(negedge clk);
        check(q_ready && !resp_valid, "R10", {30'h0, q_ready, resp_valid}, 2);

        finish_run();
    end

endmodule